// File: doc/BRIEF.md
# Jiffy Timekeeping Unit

This block turns a stream of 100 Hz timer interrupts ("jiffies") into three counters. The first is a free-running uptime count in seconds. The second is a wall-clock seconds count that software can set. The third is a seconds countdown for timed delays, which raises a completion flag when it expires. All three share one divide-by-100 prescaler, so they advance together on the same one-second boundary.

A raw tick counts only when the interrupt-status flag of the selected timer source is also high. Ticks that arrive without that confirmation, and status flags without a tick, are discarded. Software reaches the block through a single-cycle write port. Address 0 loads the wall-clock count and address 1 starts a delay. All counters can be read directly on output ports.

Top module: `jiffy_timekeeper`

## Requirements
- R1: After reset, uptime, wall-clock and delay counters read zero, and the delay-done flag is low.
- R2: A tick is accepted only in a cycle where `tick_i` is high and `src_flags_i[src_sel_i]` is high. Any other tick or flag pattern leaves every counter and the prescaler phase unchanged.
- R3: Every 100th accepted tick produces one second update. The uptime output shows the increment in the cycle after the clock edge that takes that tick.
- R4: The uptime counter cannot be loaded. It wraps modulo 2^UPTIME_W (32 bits by default).
- R5: A write to address 0 loads all 40 bits of `wr_data_i` into the wall-clock counter in one cycle. It also clears the prescaler, and any tick accepted in that same cycle is dropped. The next second update comes after 100 further accepted ticks.
- R6: The wall-clock counter advances by one on each second update and wraps from all ones to zero.
- R7: A write to address 1 loads the low 16 bits of `wr_data_i` into the delay counter and clears the done flag. The counter then decrements by one on each second update.
- R8: When the delay counter steps from 1 to 0, the done flag rises in that same update. The counter then holds at zero with done high until the next delay write.
- R9: A delay write while a delay is running, or after one has finished, reloads the counter with the new value and clears the done flag.
- R10: A delay write with the value zero sets the done flag in the cycle after the write.
- R11: Register writes leave the uptime counter unchanged. A delay write does not disturb the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Raw jiffy tick, one cycle wide |
| src_flags_i | input | 4 | Interrupt-status flags, one per timer source |
| src_sel_i | input | 2 | Index of the configured timer source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 wall clock, 1 delay |
| wr_data_i | input | 40 | Write data |
| uptime_o | output | 32 | Seconds since reset |
| epoch_o | output | 40 | Loadable wall-clock seconds |
| delay_o | output | 16 | Remaining delay seconds |
| delay_done_o | output | 1 | Delay expired |

## Verification
The prescaler is driven with three kinds of pattern: confirmed ticks, ticks whose flag belongs to an unselected source, and flags that arrive with no tick. After the rejected patterns the bench counts exactly 99 good ticks and then one more. This separates correct filtering from a prescaler that counted junk, and it separates an off-by-one boundary from a correct one. Wall-clock loads are placed in mid-second, so a prescaler that is cleared can be told apart from one that keeps its old phase. Delay loads cover a normal run, a restart in mid-run and after expiry, and a zero load. A second, narrow instance counts its uptime past the top value to show the wrap.

// File: rtl/jtk_pkg.sv
package jtk_pkg;
    typedef enum logic {
        WR_EPOCH = 1'b0,
        WR_DELAY = 1'b1
    } wr_sel_e;
endpackage

// File: rtl/jtk_tick_gate.sv
module jtk_tick_gate #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               tick_i,
    input  logic [NUM_SRC-1:0] src_flags_i,
    input  logic [SEL_W-1:0]   src_sel_i,
    output logic               tick_ok_o
);
    logic sel_in_range;
    logic sel_flag;

    always_comb begin
        sel_in_range = (32'(src_sel_i) < NUM_SRC);
        sel_flag     = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (32'(src_sel_i) == i) sel_flag = src_flags_i[i];
        end
        tick_ok_o = tick_i && sel_in_range && sel_flag;
    end
endmodule

// File: rtl/jtk_prescaler.sv
module jtk_prescaler #(
    parameter int JIFFIES_PER_SEC = 100,
    localparam int CNT_W = (JIFFIES_PER_SEC > 1) ? $clog2(JIFFIES_PER_SEC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ok_i,
    input  logic clear_i,
    output logic sec_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(JIFFIES_PER_SEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        sec_o = 1'b0;
        if (clear_i) begin
            st_d.count = '0;
        end else if (tick_ok_i) begin
            if (st_q.count == LAST) begin
                st_d.count = '0;
                sec_o      = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the phase counter never leaves its range
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.count) < JIFFIES_PER_SEC);

    // R2: without an accepted tick or a clear, the phase is frozen
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ok_i && !clear_i) |=> $stable(st_q.count));

    // R5: a clear restarts the phase at zero
    p_clear_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.count == '0));
endmodule

// File: rtl/jtk_delay.sv
module jtk_delay #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [DELAY_W-1:0] load_val_i,
    input  logic               sec_i,
    output logic [DELAY_W-1:0] cnt_o,
    output logic               done_o
);
    typedef struct packed {
        logic [DELAY_W-1:0] cnt;
        logic               done;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt  = load_val_i;
            st_d.done = (load_val_i == '0);
        end else if (sec_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == DELAY_W'(1)) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;

    // R8: a finished delay sits at zero
    p_done_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.cnt == '0));

    // R8: done stays up until a new load
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !load_i) |=> st_q.done);

    // R7: a load takes the written value
    p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(load_val_i)));

    // R9: a nonzero load clears done
    p_load_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !st_q.done);
endmodule

// File: rtl/jiffy_timekeeper.sv
module jiffy_timekeeper #(
    parameter int JIFFIES_PER_SEC = 100,
    parameter int UPTIME_W        = 32,
    parameter int EPOCH_W         = 40,
    parameter int DELAY_W         = 16,
    parameter int NUM_SRC         = 4,
    localparam int SEL_W          = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [NUM_SRC-1:0]  src_flags_i,
    input  logic [SEL_W-1:0]    src_sel_i,
    input  logic                wr_en_i,
    input  logic                wr_addr_i,
    input  logic [EPOCH_W-1:0]  wr_data_i,
    output logic [UPTIME_W-1:0] uptime_o,
    output logic [EPOCH_W-1:0]  epoch_o,
    output logic [DELAY_W-1:0]  delay_o,
    output logic                delay_done_o
);
    import jtk_pkg::*;

    typedef struct packed {
        logic [UPTIME_W-1:0] uptime;
        logic [EPOCH_W-1:0]  epoch;
    } clk_state_t;

    clk_state_t st_d, st_q;

    logic tick_ok;
    logic sec_pulse;
    logic epoch_wr;
    logic delay_wr;

    assign epoch_wr = wr_en_i && (wr_sel_e'(wr_addr_i) == WR_EPOCH);
    assign delay_wr = wr_en_i && (wr_sel_e'(wr_addr_i) == WR_DELAY);

    jtk_tick_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .tick_i      (tick_i),
        .src_flags_i (src_flags_i),
        .src_sel_i   (src_sel_i),
        .tick_ok_o   (tick_ok)
    );

    jtk_prescaler #(.JIFFIES_PER_SEC(JIFFIES_PER_SEC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ok_i (tick_ok),
        .clear_i   (epoch_wr),
        .sec_o     (sec_pulse)
    );

    jtk_delay #(.DELAY_W(DELAY_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (delay_wr),
        .load_val_i (wr_data_i[DELAY_W-1:0]),
        .sec_i      (sec_pulse),
        .cnt_o      (delay_o),
        .done_o     (delay_done_o)
    );

    always_comb begin
        st_d = st_q;
        if (sec_pulse) st_d.uptime = st_q.uptime + 1'b1;
        if (epoch_wr) begin
            st_d.epoch = wr_data_i;
        end else if (sec_pulse) begin
            st_d.epoch = st_q.epoch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uptime_o = st_q.uptime;
    assign epoch_o  = st_q.epoch;

    // R3: uptime only ever moves by exactly one
    p_uptime_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.uptime != $past(st_q.uptime)) |-> (st_q.uptime == $past(st_q.uptime) + 1'b1));

    // R5: wall-clock write lands whole
    p_epoch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_wr |=> (st_q.epoch == $past(wr_data_i)));

    // R11: a write never moves uptime
    p_write_keeps_uptime_r11: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_wr |=> $stable(st_q.uptime));
endmodule

// File: tb/jiffy_timekeeper_bench.sv
module jiffy_timekeeper_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  flags = '0;
    logic [1:0]  sel = 2'd1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [39:0] wr_data = '0;
    logic [31:0] uptime;
    logic [39:0] epoch;
    logic [15:0] delay;
    logic        done;

    logic        s_tick = 1'b0;
    logic [3:0]  s_uptime;
    logic [39:0] s_epoch;
    logic [15:0] s_delay;
    logic        s_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jiffy_timekeeper u_jiffy_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .src_flags_i(flags),
        .src_sel_i(sel), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .uptime_o(uptime), .epoch_o(epoch),
        .delay_o(delay), .delay_done_o(done)
    );

    jiffy_timekeeper #(.JIFFIES_PER_SEC(4), .UPTIME_W(4)) u_small (
        .clk(clk), .rst_n(rst_n), .tick_i(s_tick), .src_flags_i(4'b0001),
        .src_sel_i(2'd0), .wr_en_i(1'b0), .wr_addr_i(1'b0),
        .wr_data_i(40'd0), .uptime_o(s_uptime), .epoch_o(s_epoch),
        .delay_o(s_delay), .delay_done_o(s_done)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic good_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; flags = 4'b0010; sel = 2'd1;
            @(negedge clk);
            tick = 1'b0; flags = '0;
        end
    endtask

    task automatic write_reg(input logic addr, input logic [39:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        check("R1 uptime", 64'(uptime), 0);
        check("R1 epoch", 64'(epoch), 0);
        check("R1 delay", 64'(delay), 0);
        check("R1 done", 64'(done), 0);
    endtask

    task automatic t_filter_and_second;
        for (int i = 0; i < 150; i++) begin
            tick = 1'b1; flags = 4'b1101; sel = 2'd1;
            @(negedge clk);
            tick = 1'b0; flags = 4'b0010;
            @(negedge clk);
        end
        flags = '0;
        check("R2 uptime after rejected ticks", 64'(uptime), 0);
        check("R2 epoch after rejected ticks", 64'(epoch), 0);
        good_ticks(99);
        check("R2 R3 no update at 99", 64'(uptime), 0);
        good_ticks(1);
        check("R3 update at 100", 64'(uptime), 1);
        check("R6 epoch follows", 64'(epoch), 1);
    endtask

    task automatic t_epoch_load;
        logic [31:0] up0;
        up0 = uptime;
        good_ticks(50);
        write_reg(1'b0, 40'hAB_CDEF_1234);
        check("R5 epoch loaded", 64'(epoch), 64'h00AB_CDEF_1234);
        check("R11 uptime kept on write", 64'(uptime), 64'(up0));
        good_ticks(99);
        check("R5 prescaler cleared", 64'(epoch), 64'h00AB_CDEF_1234);
        good_ticks(1);
        check("R5 R6 epoch step", 64'(epoch), 64'h00AB_CDEF_1235);
        check("R3 uptime step", 64'(uptime), 64'(up0 + 1));
        write_reg(1'b0, 40'hFF_FFFF_FFFF);
        good_ticks(100);
        check("R6 epoch wrap", 64'(epoch), 0);
    endtask

    task automatic t_delay_run;
        write_reg(1'b1, 40'hFF_FFFF_0003);
        check("R7 delay loaded", 64'(delay), 3);
        check("R7 done low", 64'(done), 0);
        good_ticks(100);
        check("R7 decrement", 64'(delay), 2);
        good_ticks(40);
        write_reg(1'b1, 40'h0000_0002);
        check("R11 delay write keeps phase", 64'(delay), 2);
        good_ticks(60);
        check("R11 phase kept", 64'(delay), 1);
        good_ticks(100);
        check("R8 reached zero", 64'(delay), 0);
        check("R8 done raised", 64'(done), 1);
        good_ticks(200);
        check("R8 holds zero", 64'(delay), 0);
        check("R8 done held", 64'(done), 1);
    endtask

    task automatic t_restart;
        write_reg(1'b1, 40'd5);
        check("R9 reload after done", 64'(delay), 5);
        check("R9 done cleared", 64'(done), 0);
        good_ticks(100);
        check("R9 running", 64'(delay), 4);
        write_reg(1'b1, 40'd2);
        check("R9 reload mid-run", 64'(delay), 2);
        check("R9 done still low", 64'(done), 0);
        write_reg(1'b1, 40'd0);
        check("R10 zero load done", 64'(done), 1);
        check("R10 zero count", 64'(delay), 0);
    endtask

    task automatic t_uptime_wrap;
        for (int i = 0; i < 60; i++) begin
            s_tick = 1'b1; @(negedge clk); s_tick = 1'b0;
        end
        check("R4 narrow uptime at top", 64'(s_uptime), 15);
        for (int i = 0; i < 4; i++) begin
            s_tick = 1'b1; @(negedge clk); s_tick = 1'b0;
        end
        check("R4 narrow uptime wraps", 64'(s_uptime), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_filter_and_second();
        t_epoch_load();
        t_delay_run();
        t_restart();
        t_uptime_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule